// File: doc/BRIEF.md
# Escalating Hang-Recovery Watchdog

This block watches over a processor that can stop working after a radiation upset without suffering lasting damage. Software running on the processor proves that it is alive by writing to a kick address of a small register port. If no kick arrives before a programmable check limit runs out, the block sets a sticky hang flag and begins recovery. It tries the mildest action first and the harshest action last. It raises interrupt lines one at a time in ascending index order, and each line has its own polarity and pulse width. After the interrupts it pulses the processor reset. The final action is a power-cycle enable that feeds an external power-switch driver.

After every action the block opens a response window. A kick inside that window ends the escalation and monitoring resumes with a fresh timer. Software can use a mask to remove individual interrupt rungs from the ladder. After a power cycle, a separate boot-grace limit gives the processor longer to start up. An external abort input stops any escalation and restarts the timer. The registers are written with single-cycle write strobes and are read through a combinational read port. The block has no data stream, so no pin uses a valid/ready handshake.

Top module: `sefi_recovery_wdog`

## Requirements
- R1: After rst_n is released, sefi_flag_o is 0, cpu_rst_o and pwr_cycle_o are 0, and every irq_o line sits at its inactive level. The polarity register resets to all ones, so every line reads 0. The check-limit register (address 2) reads back its parameter default.
- R2: While monitoring, a write to address 0 (kick) restarts the check timer. With check limit L (address 2) and no further kick, sefi_flag_o rises on the (L+1)-th clock edge after the edge that captured the kick. The first rung starts on that same edge.
- R3: Bit i of the polarity register (address 6) gives the active level of irq_o[i]: 1 means active high and 0 means active low. Each line is active for exactly max(W,1) cycles, where W is its width register at address 8+i. A line is at the inverse level at all other times.
- R4: Only one recovery action is active at a time. The order is the enabled interrupt rungs in ascending index, then cpu_rst_o for RST_LEN cycles, then pwr_cycle_o.
- R5: A 0 in bit i of the rung mask (address 7) removes interrupt rung i from the ladder. A removed rung takes no cycles: the next enabled rung, or the reset, starts on the same edge that ends the previous response window. Each response window lasts R+1 cycles, where R is at address 3.
- R6: A kick during any action or window drives every action output inactive on the next edge. Monitoring then resumes with the check timer restarted from that kick.
- R7: Address 1 reads the flag in bit 0 and the index of the last rung in bits 8 and up. Interrupt rungs use indices 0..N-1, reset uses N and power uses N+1. The flag stays set until a write to address 1 with data bit 0 = 1; a write with bit 0 = 0 leaves it set.
- R8: ext_rst_i high aborts any escalation. On the next edge every action output goes inactive and the check timer restarts from 0. The flag is kept.
- R9: pwr_cycle_o stays high for OFF+1 cycles (OFF at address 4). A boot-grace window of G+1 cycles follows (G at address 5). A kick inside that window resumes monitoring. If no kick arrives, the flag is set again and the ladder restarts at the first enabled rung.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| ext_rst_i | input | 1 | External abort/restart of the watchdog |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | DW | Register write data |
| rd_addr_i | input | AW | Register read address |
| rd_data_o | output | DW | Register read data (combinational) |
| irq_o | output | N_IRQ | Interrupt lines toward the processor |
| cpu_rst_o | output | 1 | Processor reset pulse, active high |
| pwr_cycle_o | output | 1 | Power-switch driver enable, active high |
| sefi_flag_o | output | 1 | Sticky hang flag |

## Verification
The checker checks four things on every cycle. Interrupt lines are never active together, and at most one of interrupt, reset and power is active at once. A kick or an external abort always leaves every action output inactive on the next cycle. The flag never falls unless software writes the clear. The cycle-exact lengths of the timeouts, pulses, windows and off-times, the ascending order that skips masked rungs, polarity handling, the last-rung field and the restart of the ladder after the boot grace all depend on programmed values and sequences, so only the bench scenarios can show them.

// File: rtl/sefi_wdog_pkg.sv
package sefi_wdog_pkg;

  typedef enum logic [2:0] {
    LAD_MON,
    LAD_PULSE,
    LAD_WAIT,
    LAD_RST,
    LAD_RWAIT,
    LAD_PWR,
    LAD_BOOT
  } lad_state_t;

  // register addresses (the kick/status/limit decode order is fixed by software)
  localparam int unsigned ADR_KICK  = 0;
  localparam int unsigned ADR_STAT  = 1;
  localparam int unsigned ADR_CHK   = 2;
  localparam int unsigned ADR_RESP  = 3;
  localparam int unsigned ADR_OFF   = 4;
  localparam int unsigned ADR_GRACE = 5;
  localparam int unsigned ADR_POL   = 6;
  localparam int unsigned ADR_MASK  = 7;
  localparam int unsigned ADR_PW0   = 8;

  localparam int unsigned STAT_RUNG_LSB = 8;

endpackage

// File: rtl/sefi_cfg_regs.sv
module sefi_cfg_regs
  import sefi_wdog_pkg::*;
#(
  parameter int unsigned N_IRQ     = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 5,
  parameter int unsigned RW        = 4,
  parameter int unsigned CHK_DEF   = 1000,
  parameter int unsigned RESP_DEF  = 100,
  parameter int unsigned OFF_DEF   = 200,
  parameter int unsigned GRACE_DEF = 2000,
  parameter int unsigned PW_DEF    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic [AW-1:0]              rd_addr_i,
  output logic [DW-1:0]              rd_data_o,
  input  logic                       sefi_set_i,
  input  logic [RW-1:0]              rung_i,
  output logic                       kick_o,
  output logic [DW-1:0]              chk_lim_o,
  output logic [DW-1:0]              resp_lim_o,
  output logic [DW-1:0]              off_lim_o,
  output logic [DW-1:0]              grace_lim_o,
  output logic [N_IRQ-1:0]           pol_o,
  output logic [N_IRQ-1:0]           mask_o,
  output logic [N_IRQ-1:0][DW-1:0]   width_o,
  output logic                       flag_o
);

  logic [DW-1:0]            chk_q, resp_q, off_q, grace_q;
  logic [N_IRQ-1:0]         pol_q, mask_q;
  logic [N_IRQ-1:0][DW-1:0] width_q;
  logic                     flag_q;
  logic                     clr_req;

  assign kick_o  = wr_en_i && (wr_addr_i == AW'(ADR_KICK));
  assign clr_req = wr_en_i && (wr_addr_i == AW'(ADR_STAT)) && wr_data_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q   <= DW'(CHK_DEF);
      resp_q  <= DW'(RESP_DEF);
      off_q   <= DW'(OFF_DEF);
      grace_q <= DW'(GRACE_DEF);
      pol_q   <= '1;
      mask_q  <= '1;
      for (int i = 0; i < N_IRQ; i++) width_q[i] <= DW'(PW_DEF);
    end else if (wr_en_i) begin
      case (wr_addr_i)
        AW'(ADR_CHK):   chk_q   <= wr_data_i;
        AW'(ADR_RESP):  resp_q  <= wr_data_i;
        AW'(ADR_OFF):   off_q   <= wr_data_i;
        AW'(ADR_GRACE): grace_q <= wr_data_i;
        AW'(ADR_POL):   pol_q   <= wr_data_i[N_IRQ-1:0];
        AW'(ADR_MASK):  mask_q  <= wr_data_i[N_IRQ-1:0];
        default: ;
      endcase
      for (int i = 0; i < N_IRQ; i++) begin
        if (wr_addr_i == AW'(ADR_PW0 + i)) width_q[i] <= wr_data_i;
      end
    end
  end

  // sticky flag: a new declaration wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (sefi_set_i) flag_q <= 1'b1;
    else if (clr_req)    flag_q <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      AW'(ADR_STAT): begin
        rd_data_o[0] = flag_q;
        rd_data_o[STAT_RUNG_LSB +: RW] = rung_i;
      end
      AW'(ADR_CHK):   rd_data_o = chk_q;
      AW'(ADR_RESP):  rd_data_o = resp_q;
      AW'(ADR_OFF):   rd_data_o = off_q;
      AW'(ADR_GRACE): rd_data_o = grace_q;
      AW'(ADR_POL):   rd_data_o[N_IRQ-1:0] = pol_q;
      AW'(ADR_MASK):  rd_data_o[N_IRQ-1:0] = mask_q;
      default: ;
    endcase
    for (int i = 0; i < N_IRQ; i++) begin
      if (rd_addr_i == AW'(ADR_PW0 + i)) rd_data_o = width_q[i];
    end
  end

  assign chk_lim_o   = chk_q;
  assign resp_lim_o  = resp_q;
  assign off_lim_o   = off_q;
  assign grace_lim_o = grace_q;
  assign pol_o       = pol_q;
  assign mask_o      = mask_q;
  assign width_o     = width_q;
  assign flag_o      = flag_q;

endmodule

// File: rtl/sefi_irq_pulse.sv
module sefi_irq_pulse #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic          clear_i,
  input  logic          pol_i,
  input  logic [DW-1:0] width_i,
  output logic          irq_o,
  output logic          done_o
);

  logic [DW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (clear_i)        left_q <= '0;
    else if (fire_i)         left_q <= (width_i == '0) ? DW'(1) : width_i;
    else if (left_q != '0)   left_q <= left_q - DW'(1);
  end

  assign irq_o  = (left_q != '0) ? pol_i : ~pol_i;
  assign done_o = (left_q == DW'(1));

endmodule

// File: rtl/sefi_ladder.sv
module sefi_ladder
  import sefi_wdog_pkg::*;
#(
  parameter int unsigned N_IRQ   = 8,
  parameter int unsigned DW      = 16,
  parameter int unsigned RW      = 4,
  parameter int unsigned RST_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_rst_i,
  input  logic             kick_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic [N_IRQ-1:0] done_i,
  input  logic [DW-1:0]    chk_lim_i,
  input  logic [DW-1:0]    resp_lim_i,
  input  logic [DW-1:0]    off_lim_i,
  input  logic [DW-1:0]    grace_lim_i,
  output logic [N_IRQ-1:0] fire_o,
  output logic             abort_o,
  output logic             cpu_rst_o,
  output logic             pwr_o,
  output logic             sefi_set_o,
  output logic [RW-1:0]    rung_o
);

  localparam logic [RW-1:0] RUNG_RST = RW'(N_IRQ);
  localparam logic [RW-1:0] RUNG_PWR = RW'(N_IRQ + 1);
  localparam logic [DW-1:0] RST_LAST = DW'(RST_LEN - 1);

  lad_state_t       st_q, st_n;
  logic [DW-1:0]    cnt_q, cnt_n;
  logic [RW-1:0]    rung_q, rung_n;

  logic             first_ok, next_ok, sel_done;
  logic [RW-1:0]    first_idx, next_idx;
  logic [N_IRQ-1:0] first_oh, next_oh;

  // lowest enabled rung overall, and lowest enabled rung above the current one
  always_comb begin
    first_ok = 1'b0; first_idx = '0; first_oh = '0;
    next_ok  = 1'b0; next_idx  = '0; next_oh  = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        first_ok  = 1'b1;
        first_idx = RW'(i);
        first_oh  = '0;
        first_oh[i] = 1'b1;
      end
      if (mask_i[i] && (RW'(i) > rung_q)) begin
        next_ok  = 1'b1;
        next_idx = RW'(i);
        next_oh  = '0;
        next_oh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    sel_done = 1'b0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (rung_q == RW'(i)) sel_done = done_i[i];
    end
  end

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q + DW'(1);
    rung_n     = rung_q;
    fire_o     = '0;
    abort_o    = 1'b0;
    sefi_set_o = 1'b0;
    if (ext_rst_i || (kick_i && (st_q != LAD_MON))) begin
      st_n    = LAD_MON;
      cnt_n   = '0;
      abort_o = 1'b1;
    end else begin
      case (st_q)
        LAD_MON, LAD_BOOT: begin
          if (kick_i) begin
            st_n  = LAD_MON;
            cnt_n = '0;
          end else if (cnt_q >= ((st_q == LAD_MON) ? chk_lim_i : grace_lim_i)) begin
            sefi_set_o = 1'b1;
            cnt_n      = '0;
            if (first_ok) begin
              st_n   = LAD_PULSE;
              rung_n = first_idx;
              fire_o = first_oh;
            end else begin
              st_n   = LAD_RST;
              rung_n = RUNG_RST;
            end
          end
        end
        LAD_PULSE: begin
          cnt_n = cnt_q;
          if (sel_done) begin
            st_n  = LAD_WAIT;
            cnt_n = '0;
          end
        end
        LAD_WAIT: begin
          if (cnt_q >= resp_lim_i) begin
            cnt_n = '0;
            if (next_ok) begin
              st_n   = LAD_PULSE;
              rung_n = next_idx;
              fire_o = next_oh;
            end else begin
              st_n   = LAD_RST;
              rung_n = RUNG_RST;
            end
          end
        end
        LAD_RST: begin
          if (cnt_q >= RST_LAST) begin
            st_n  = LAD_RWAIT;
            cnt_n = '0;
          end
        end
        LAD_RWAIT: begin
          if (cnt_q >= resp_lim_i) begin
            st_n   = LAD_PWR;
            cnt_n  = '0;
            rung_n = RUNG_PWR;
          end
        end
        LAD_PWR: begin
          if (cnt_q >= off_lim_i) begin
            st_n  = LAD_BOOT;
            cnt_n = '0;
          end
        end
        default: begin
          st_n  = LAD_MON;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LAD_MON;
      cnt_q  <= '0;
      rung_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      rung_q <= rung_n;
    end
  end

  assign cpu_rst_o = (st_q == LAD_RST);
  assign pwr_o     = (st_q == LAD_PWR);
  assign rung_o    = rung_q;

endmodule

// File: rtl/sefi_recovery_wdog.sv
module sefi_recovery_wdog
  import sefi_wdog_pkg::*;
#(
  parameter int unsigned N_IRQ     = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 5,
  parameter int unsigned RST_LEN   = 16,
  parameter int unsigned CHK_DEF   = 1000,
  parameter int unsigned RESP_DEF  = 100,
  parameter int unsigned OFF_DEF   = 200,
  parameter int unsigned GRACE_DEF = 2000,
  parameter int unsigned PW_DEF    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_rst_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [N_IRQ-1:0] irq_o,
  output logic             cpu_rst_o,
  output logic             pwr_cycle_o,
  output logic             sefi_flag_o
);

  localparam int unsigned RW = $clog2(N_IRQ + 2);

  logic                     kick_w, set_w, abort_w;
  logic [DW-1:0]            chk_w, resp_w, off_w, grace_w;
  logic [N_IRQ-1:0]         pol_w, mask_w, fire_w, done_w;
  logic [N_IRQ-1:0][DW-1:0] width_w;
  logic [RW-1:0]            rung_w;

  sefi_cfg_regs #(
    .N_IRQ(N_IRQ), .DW(DW), .AW(AW), .RW(RW),
    .CHK_DEF(CHK_DEF), .RESP_DEF(RESP_DEF), .OFF_DEF(OFF_DEF),
    .GRACE_DEF(GRACE_DEF), .PW_DEF(PW_DEF)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .sefi_set_i(set_w), .rung_i(rung_w),
    .kick_o(kick_w), .chk_lim_o(chk_w), .resp_lim_o(resp_w),
    .off_lim_o(off_w), .grace_lim_o(grace_w),
    .pol_o(pol_w), .mask_o(mask_w), .width_o(width_w), .flag_o(sefi_flag_o)
  );

  sefi_ladder #(
    .N_IRQ(N_IRQ), .DW(DW), .RW(RW), .RST_LEN(RST_LEN)
  ) ladder_i (
    .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i), .kick_i(kick_w),
    .mask_i(mask_w), .done_i(done_w),
    .chk_lim_i(chk_w), .resp_lim_i(resp_w), .off_lim_i(off_w), .grace_lim_i(grace_w),
    .fire_o(fire_w), .abort_o(abort_w), .cpu_rst_o(cpu_rst_o), .pwr_o(pwr_cycle_o),
    .sefi_set_o(set_w), .rung_o(rung_w)
  );

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    sefi_irq_pulse #(.DW(DW)) pulse_i (
      .clk(clk), .rst_n(rst_n),
      .fire_i(fire_w[g]), .clear_i(abort_w),
      .pol_i(pol_w[g]), .width_i(width_w[g]),
      .irq_o(irq_o[g]), .done_o(done_w[g])
    );
  end

endmodule

// File: rtl/sefi_recovery_wdog_chk.sv
module sefi_recovery_wdog_chk
  import sefi_wdog_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_rst_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic             clr_bit,
  input logic [N_IRQ-1:0] irq_o,
  input logic [N_IRQ-1:0] pol,
  input logic             cpu_rst_o,
  input logic             pwr_cycle_o,
  input logic             sefi_flag_o
);

  logic [N_IRQ-1:0] act;
  logic             kick, clr;

  assign act  = ~(irq_o ^ pol);
  assign kick = wr_en_i && (wr_addr_i == AW'(ADR_KICK));
  assign clr  = wr_en_i && (wr_addr_i == AW'(ADR_STAT)) && clr_bit;

  AST_ONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act)); // R4
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|act, cpu_rst_o, pwr_cycle_o})); // R4
  AST_KICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (act == '0 && !cpu_rst_o && !pwr_cycle_o)); // R6
  AST_EXT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_i |=> (act == '0 && !cpu_rst_o && !pwr_cycle_o)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sefi_flag_o && !clr) |=> sefi_flag_o); // R7

endmodule

bind sefi_recovery_wdog sefi_recovery_wdog_chk #(.N_IRQ(N_IRQ), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .clr_bit(wr_data_i[0]),
  .irq_o(irq_o), .pol(pol_w), .cpu_rst_o(cpu_rst_o),
  .pwr_cycle_o(pwr_cycle_o), .sefi_flag_o(sefi_flag_o)
);

// File: tb/sefi_recovery_wdog_tb_top.sv
module sefi_recovery_wdog_tb_top;

  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int RSTL = 4;
  localparam int CHKD = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_rst_i = 1'b1;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [N-1:0]  irq_o;
  logic          cpu_rst_o, pwr_cycle_o, sefi_flag_o;

  int total = 0;
  int bad = 0;
  bit ended = 0;
  logic [N-1:0] pol_tb = '1;

  always #10 clk = ~clk;

  sefi_recovery_wdog #(
    .N_IRQ(N), .DW(DW), .AW(AW), .RST_LEN(RSTL), .CHK_DEF(CHKD),
    .RESP_DEF(10), .OFF_DEF(10), .GRACE_DEF(20), .PW_DEF(2)
  ) dut_i (.*);

  // {mask, polarity, check limit, expected first rung}
  localparam logic [27:0] VEC [6] = '{
    {8'hFF, 8'hFF, 8'd5, 4'd0},
    {8'hFE, 8'hFF, 8'd3, 4'd1},
    {8'h80, 8'h00, 8'd7, 4'd7},
    {8'h30, 8'h0F, 8'd0, 4'd4},
    {8'h00, 8'hFF, 8'd4, 4'd8},
    {8'h0A, 8'hAA, 8'd2, 4'd1}
  };

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_en_i = 1'b1; wr_addr_i = AW'(addr); wr_data_i = DW'(data);
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  function automatic bit sig(input int s);
    if (s < N)  return irq_o[s] == pol_tb[s];
    if (s == 8) return cpu_rst_o;
    if (s == 9) return pwr_cycle_o;
    return sefi_flag_o;
  endfunction

  // cycles until signal s becomes active
  task automatic wait_hi(input int s, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sig(s) && n < 400);
  endtask

  // cycles signal s stays active (entered while active)
  task automatic count_hi(input int s, output int n);
    n = 0;
    while (sig(s) && n < 400) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input int addr, output int v);
    rd_addr_i = AW'(addr);
    #1;
    v = int'(rd_data_o);
  endtask

  function automatic int idle_ok();
    return (irq_o == ~pol_tb && !cpu_rst_o && !pwr_cycle_o) ? 1 : 0;
  endfunction

  task automatic summary();
    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
    end
  end

  initial begin
    int n, v;
    logic [N-1:0] exp_irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_eq("R1 flag", int'(sefi_flag_o), 0);
    check_eq("R1 irq", int'(irq_o), 0);
    check_eq("R1 rst/pwr", int'({cpu_rst_o, pwr_cycle_o}), 0);
    rd(2, v);
    check_eq("R1 chk default", v, CHKD);

    for (int k = 0; k < 6; k++) begin
      logic [7:0] vm, vp, vl;
      logic [3:0] ve;
      {vm, vp, vl, ve} = VEC[k];
      ext_rst_i = 1'b1;
      wr(7, int'(vm));
      wr(6, int'(vp));
      pol_tb = vp;
      wr(2, int'(vl));
      wr(1, 1);
      ext_rst_i = 1'b0;
      wr(0, 0);
      wait_hi(10, n);
      check_eq("R2 timeout cycles", n, int'(vl) + 1);
      exp_irq = ~vp;
      if (ve < 4'd8) exp_irq[ve] = vp[ve];
      check_eq("R3/R5 irq pattern", int'(irq_o), int'(exp_irq));
      check_eq("R4 reset rung", int'(cpu_rst_o), (ve == 4'd8) ? 1 : 0);
      rd(1, v);
      check_eq("R7 last rung", (v >> 8) & 15, int'(ve));
      wr(0, 0);
      check_eq("R6 idle after kick", idle_ok(), 1);
    end

    // directed ladder walk
    ext_rst_i = 1'b1;
    wr(7, 'h05); wr(6, 'hFF); pol_tb = '1;
    wr(2, 4); wr(3, 2); wr(4, 3); wr(5, 5);
    wr(8, 3); wr(10, 0);
    wr(1, 1);
    ext_rst_i = 1'b0;
    wr(0, 0);
    wait_hi(10, n);
    check_eq("R2 timeout", n, 5);
    count_hi(0, n);
    check_eq("R3 width 3", n, 3);
    wait_hi(2, n);
    check_eq("R5 skip gap", n, 3);
    count_hi(2, n);
    check_eq("R3 width 0 as 1", n, 1);
    wait_hi(8, n);
    check_eq("R4 reset after irqs", n, 3);
    count_hi(8, n);
    check_eq("R4 reset length", n, RSTL);
    wait_hi(9, n);
    check_eq("R4 power after reset", n, 3);
    count_hi(9, n);
    check_eq("R9 off time", n, 4);
    rd(1, v);
    check_eq("R7 last rung power", (v >> 8) & 15, N + 1);
    wait_hi(0, n);
    check_eq("R9 boot grace restart", n, 6);
    wr(1, 0);
    check_eq("R7 write 0 keeps flag", int'(sefi_flag_o), 1);
    wr(1, 1);
    check_eq("R7 W1C clears", int'(sefi_flag_o), 0);
    wr(0, 0);
    check_eq("R6 kick recovers", idle_ok(), 1);
    wait_hi(10, n);
    check_eq("R6 timer restarted", n, 5);

    // R8: external abort mid-pulse
    check_eq("R8 pulse running", int'(irq_o[0]), 1);
    ext_rst_i = 1'b1;
    @(negedge clk);
    ext_rst_i = 1'b0;
    check_eq("R8 abort idle", idle_ok(), 1);
    check_eq("R8 flag kept", int'(sefi_flag_o), 1);
    wait_hi(0, n);
    check_eq("R8 timer restart", n, 5);

    summary();
  end

endmodule